// File: doc/BRIEF.md
# Multiplexed Segment LCD Driver

This block drives a segment LCD in time-division fashion. A small bank of backplane electrodes is scanned one at a time, and each frontplane electrode carries the segment states of its data column for whichever backplane is active. As a result, many segments share few pins. The block does not generate analog voltages. Every electrode output is a 2-bit level-select code that an external bias network turns into one of four drive levels, V0 (code 0) through V3 (code 3).

Software stores segment bits and blink masks through a simple write port. Each column holds one byte, and bit b belongs to backplane b. Software also sets a frontplane pin map that lets any physical pin show any data column. The scan runs either four or eight backplanes per frame, chosen by an input.

A three-state sequencer controls the scan:
- `ST_OFF` is the disabled state. It moves to `ST_LOAD` when `enable` is high.
- `ST_LOAD` is a single zero-bias gap cycle. In this cycle the staged memory, the blink masks and the scan length are copied into the working copy. It moves to `ST_DRIVE`, or back to `ST_OFF` if `enable` has dropped.
- `ST_DRIVE` steps the backplane phases. After the final phase it returns to `ST_LOAD`, and the drive polarity flips. Dropping `enable` sends it to `ST_OFF`.

Blinking hides masked segments during alternate stretches of frames with no processor action. The length of each stretch is chosen by a tap on a frame counter.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge that samples `enable` low, every backplane and frontplane code is 0, which is zero bias.
- R2: In a drive cycle of an even frame, the active backplane shows code 3 and the other in-use backplanes show code 1. In an odd frame, the active backplane shows code 0 and the others show code 2. Backplanes beyond the in-use count always show code 0.
- R3: After a one-cycle all-zero gap, a frame steps backplanes 0, 1, 2 and onward in order. Each backplane is held for PHASE_CYCLES clock cycles. After the last in-use backplane, a new gap cycle follows.
- R4: A frontplane shows the on level when the segment bit of its column, at the position of the active backplane, is 1. The on level is code 0 in even frames and code 3 in odd frames. Otherwise the frontplane shows the off level, which is code 2 in even frames and code 1 in odd frames.
- R5: Drive polarity alternates from frame to frame. The first frame after `enable` rises is even.
- R6: Segment and blink-mask writes (target 0 and target 1) go to a staging copy. They reach the outputs only from the frame that begins after the next gap cycle.
- R7: Pin map entry p (target 2, data bits [IDXW-1:0]) selects the column shown on frontplane p. After reset, entry p selects column p. An entry of NUM_FP or more holds that pin at the off level.
- R8: A frame counter starts at 0 when the scan starts and increments at each gap. While `blink_en` is high and counter bit `blink_tap` is 1, segments whose blink-mask bit is set are shown off.
- R9: Writes with target 3, or with an index of NUM_FP or more, change nothing.
- R10: `mux8_sel` is sampled only in the gap cycle. A value of 0 gives 4 backplanes and a value of 1 gives 8. A change in the middle of a frame does not alter the length of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Scan enable; low forces zero-bias codes |
| mux8_sel | input | 1 | 0: four backplanes, 1: eight backplanes |
| blink_en | input | 1 | Enables hiding of blink-masked segments |
| blink_tap | input | $clog2(FRAME_W) | Frame counter bit that sets the blink rhythm |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 2 | 0 segments, 1 blink mask, 2 pin map, 3 none |
| wr_index | input | $clog2(NUM_FP) | Column index, or pin index for map writes |
| wr_data | input | BP_MAX | Per-backplane bits, or a column number in the low bits |
| bp_lvl | output | 2*BP_MAX | Backplane level codes, 2 bits per backplane |
| fp_lvl | output | 2*NUM_FP | Frontplane level codes, 2 bits per pin |

## Verification
The bench builds the driver with six frontplanes, eight backplanes, three cycles per phase and a four-bit frame counter. The six-column setting leaves two index codes (6 and 7) unused. This makes both out-of-range writes and out-of-range map entries reachable. The short phase makes full 4:1 and 8:1 frames cheap enough to compare code by code. The narrow frame counter lets both blink taps show their hidden frames within a few frames of each start.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    typedef enum logic [1:0] {
        LVL_V0 = 2'd0,
        LVL_V1 = 2'd1,
        LVL_V2 = 2'd2,
        LVL_V3 = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRIVE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_SEG   = 2'd0,
        TGT_BLINK = 2'd1,
        TGT_MAP   = 2'd2,
        TGT_NONE  = 2'd3
    } wr_tgt_e;

    // Backplane level: unused electrodes sit at zero bias.
    function automatic lvl_e bp_code(input logic used, input logic sel, input logic pol);
        if (!used) return LVL_V0;
        if (sel)   return pol ? LVL_V0 : LVL_V3;
        return pol ? LVL_V2 : LVL_V1;
    endfunction

    // Frontplane level: "on" opposes the active backplane, "off" sits mid-rail.
    function automatic lvl_e fp_code(input logic on, input logic pol);
        if (on) return pol ? LVL_V3 : LVL_V0;
        return pol ? LVL_V1 : LVL_V2;
    endfunction

endpackage

// File: rtl/lcd_seg_store.sv
module lcd_seg_store
    import lcd_mux_pkg::*;
#(
    parameter int NUM_FP = 20,
    parameter int BP_MAX = 8,
    parameter int IDXW   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [1:0]                       wr_target,
    input  logic [IDXW-1:0]                  wr_index,
    input  logic [BP_MAX-1:0]                wr_data,
    input  logic                             load,
    output logic [NUM_FP-1:0][BP_MAX-1:0]    act_seg,
    output logic [NUM_FP-1:0][BP_MAX-1:0]    act_blink,
    output logic [NUM_FP-1:0][IDXW-1:0]      pin_map
);

    for (genvar c = 0; c < NUM_FP; c++) begin : g_col
        logic [BP_MAX-1:0] stage_seg_q;
        logic [BP_MAX-1:0] stage_blink_q;
        logic [BP_MAX-1:0] work_seg_q;
        logic [BP_MAX-1:0] work_blink_q;
        logic [IDXW-1:0]   map_q;
        logic              hit;

        assign hit = wr_en && (wr_index == IDXW'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_seg_q   <= '0;
                stage_blink_q <= '0;
                work_seg_q    <= '0;
                work_blink_q  <= '0;
                map_q         <= IDXW'(c);
            end else begin
                if (hit && (wr_target == TGT_SEG))   stage_seg_q   <= wr_data;
                if (hit && (wr_target == TGT_BLINK)) stage_blink_q <= wr_data;
                if (hit && (wr_target == TGT_MAP))   map_q         <= wr_data[IDXW-1:0];
                if (load) begin
                    work_seg_q   <= stage_seg_q;
                    work_blink_q <= stage_blink_q;
                end
            end
        end

        assign act_seg[c]   = work_seg_q;
        assign act_blink[c] = work_blink_q;
        assign pin_map[c]   = map_q;
    end

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_mux_pkg::*;
#(
    parameter int BP_MAX       = 8,
    parameter int PHASE_CYCLES = 64,
    parameter int FRAME_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       mux8_sel,
    output seq_state_e                 state,
    output logic [$clog2(BP_MAX)-1:0]  phase,
    output logic                       pol,
    output logic                       mode8,
    output logic [FRAME_W-1:0]         frame_cnt,
    output logic                       load
);

    localparam int PHW = $clog2(BP_MAX);
    localparam int TW  = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [TW-1:0]  TICK_LAST = TW'(PHASE_CYCLES - 1);
    localparam logic [PHW-1:0] PH_LAST8  = PHW'(BP_MAX - 1);
    localparam logic [PHW-1:0] PH_LAST4  = PHW'(BP_MAX / 2 - 1);

    seq_state_e         state_q, state_d;
    logic [TW-1:0]      tick_q;
    logic [PHW-1:0]     phase_q;
    logic               pol_q;
    logic               mode8_q;
    logic [FRAME_W-1:0] frame_q;
    logic               last_tick, last_phase;

    assign last_tick  = (tick_q == TICK_LAST);
    assign last_phase = (phase_q == (mode8_q ? PH_LAST8 : PH_LAST4));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (enable) state_d = ST_LOAD;
            ST_LOAD:  state_d = enable ? ST_DRIVE : ST_OFF;
            ST_DRIVE: begin
                if (!enable)                      state_d = ST_OFF;
                else if (last_tick && last_phase) state_d = ST_LOAD;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    // Phase, polarity and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            phase_q <= '0;
            pol_q   <= 1'b0;
            mode8_q <= 1'b0;
            frame_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    tick_q  <= '0;
                    phase_q <= '0;
                    pol_q   <= 1'b0;
                    frame_q <= '0;
                end
                ST_LOAD: begin
                    tick_q  <= '0;
                    phase_q <= '0;
                    mode8_q <= mux8_sel;
                end
                ST_DRIVE: begin
                    if (last_tick) begin
                        tick_q <= '0;
                        if (last_phase) begin
                            phase_q <= '0;
                            pol_q   <= ~pol_q;
                            frame_q <= frame_q + 1'b1;
                        end else begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: begin
                    tick_q  <= '0;
                    phase_q <= '0;
                end
            endcase
        end
    end

    assign state     = state_q;
    assign phase     = phase_q;
    assign pol       = pol_q;
    assign mode8     = mode8_q;
    assign frame_cnt = frame_q;
    assign load      = (state_q == ST_LOAD);

endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
    import lcd_mux_pkg::*;
#(
    parameter int NUM_FP = 20,
    parameter int BP_MAX = 8,
    parameter int IDXW   = 5,
    parameter int PHW    = 3
) (
    input  logic                          drive_on,
    input  logic [PHW-1:0]                phase,
    input  logic                          pol,
    input  logic                          mode8,
    input  logic                          blank,
    input  logic [NUM_FP-1:0][BP_MAX-1:0] act_seg,
    input  logic [NUM_FP-1:0][BP_MAX-1:0] act_blink,
    input  logic [NUM_FP-1:0][IDXW-1:0]   pin_map,
    output logic [BP_MAX-1:0][1:0]        bp_lvl,
    output logic [NUM_FP-1:0][1:0]        fp_lvl
);

    for (genvar b = 0; b < BP_MAX; b++) begin : g_bp
        localparam bit LOWER_HALF = (b < BP_MAX / 2);
        logic used, sel;
        assign used      = drive_on && (mode8 || LOWER_HALF);
        assign sel       = (phase == PHW'(b));
        assign bp_lvl[b] = bp_code(used, sel, pol);
    end

    for (genvar p = 0; p < NUM_FP; p++) begin : g_fp
        logic [IDXW-1:0]   col;
        logic              col_ok;
        logic [BP_MAX-1:0] seg_bits, blink_bits;
        logic              lit;
        assign col        = pin_map[p];
        assign col_ok     = ({1'b0, col} < (IDXW + 1)'(NUM_FP));
        assign seg_bits   = col_ok ? act_seg[col]   : '0;
        assign blink_bits = col_ok ? act_blink[col] : '0;
        assign lit        = seg_bits[phase] && !(blank && blink_bits[phase]);
        assign fp_lvl[p]  = drive_on ? fp_code(lit, pol) : LVL_V0;
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_mux_pkg::*;
#(
    parameter int NUM_FP       = 20,
    parameter int BP_MAX       = 8,
    parameter int PHASE_CYCLES = 64,
    parameter int FRAME_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         mux8_sel,
    input  logic                         blink_en,
    input  logic [$clog2(FRAME_W)-1:0]   blink_tap,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_target,
    input  logic [$clog2(NUM_FP)-1:0]    wr_index,
    input  logic [BP_MAX-1:0]            wr_data,
    output logic [2*BP_MAX-1:0]          bp_lvl,
    output logic [2*NUM_FP-1:0]          fp_lvl
);

    localparam int IDXW = $clog2(NUM_FP);
    localparam int PHW  = $clog2(BP_MAX);

    seq_state_e                  seq_state;
    logic [PHW-1:0]              phase;
    logic                        pol, mode8, load;
    logic [FRAME_W-1:0]          frame_cnt;
    logic [NUM_FP-1:0][BP_MAX-1:0] act_seg, act_blink;
    logic [NUM_FP-1:0][IDXW-1:0] pin_map;
    logic [BP_MAX-1:0][1:0]      bp_arr;
    logic [NUM_FP-1:0][1:0]      fp_arr;
    logic                        blank;

    lcd_phase_seq #(
        .BP_MAX(BP_MAX), .PHASE_CYCLES(PHASE_CYCLES), .FRAME_W(FRAME_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mux8_sel(mux8_sel),
        .state(seq_state), .phase(phase), .pol(pol), .mode8(mode8),
        .frame_cnt(frame_cnt), .load(load)
    );

    lcd_seg_store #(
        .NUM_FP(NUM_FP), .BP_MAX(BP_MAX), .IDXW(IDXW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
        .wr_index(wr_index), .wr_data(wr_data), .load(load),
        .act_seg(act_seg), .act_blink(act_blink), .pin_map(pin_map)
    );

    assign blank = blink_en && frame_cnt[blink_tap];

    lcd_level_drive #(
        .NUM_FP(NUM_FP), .BP_MAX(BP_MAX), .IDXW(IDXW), .PHW(PHW)
    ) u_drive (
        .drive_on(seq_state == ST_DRIVE), .phase(phase), .pol(pol),
        .mode8(mode8), .blank(blank), .act_seg(act_seg),
        .act_blink(act_blink), .pin_map(pin_map),
        .bp_lvl(bp_arr), .fp_lvl(fp_arr)
    );

    assign bp_lvl = bp_arr;
    assign fp_lvl = fp_arr;

endmodule

// File: rtl/lcd_mux_driver_sva.sv
module lcd_mux_driver_sva
    import lcd_mux_pkg::*;
#(
    parameter int NUM_FP = 20,
    parameter int BP_MAX = 8,
    parameter int PHW    = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enable,
    input logic [2*BP_MAX-1:0]           bp_lvl,
    input logic [2*NUM_FP-1:0]           fp_lvl,
    input logic [1:0]                    state,
    input logic [PHW-1:0]                phase,
    input logic                          pol,
    input logic                          mode8,
    input logic [NUM_FP-1:0][BP_MAX-1:0] act_seg
);

    logic [BP_MAX-1:0] bp_hi;
    for (genvar b = 0; b < BP_MAX; b++) begin : g_hi
        assign bp_hi[b] = (bp_lvl[2*b +: 2] == 2'b11);
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (bp_lvl == '0 && fp_lvl == '0)); // R1

    AST_SINGLE_BP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bp_hi)); // R2

    AST_BP_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && !pol) |-> ($countones(bp_hi) == 1)); // R2

    AST_BP_ODD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && pol) |-> (bp_hi == '0)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (phase == PHW'($past(phase) + 1'b1) || phase == '0)); // R3

    AST_POL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pol != $past(pol)) |-> (state == ST_LOAD || state == ST_OFF)); // R5

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> $stable(act_seg)); // R6

    AST_SHORT_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !mode8 |-> ({1'b0, phase} < (PHW + 1)'(BP_MAX / 2))); // R10

endmodule

bind lcd_mux_driver lcd_mux_driver_sva #(
    .NUM_FP(NUM_FP), .BP_MAX(BP_MAX), .PHW($clog2(BP_MAX))
) u_sva (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bp_lvl(bp_lvl),
    .fp_lvl(fp_lvl), .state(seq_state), .phase(phase), .pol(pol),
    .mode8(mode8), .act_seg(act_seg)
);

// File: tb/lcd_mux_driver_test.sv
`timescale 1ns/1ps
module lcd_mux_driver_test;

    localparam int NF = 6;
    localparam int BP = 8;
    localparam int PC = 3;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, mux8_sel = 1'b0, blink_en = 1'b0;
    logic [1:0] blink_tap = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_target = '0;
    logic [2:0] wr_index = '0;
    logic [7:0] wr_data = '0;
    logic [2*BP-1:0] bp_lvl;
    logic [2*NF-1:0] fp_lvl;

    int checks = 0, fails = 0, frame_no = 0;
    bit done = 0;
    logic [7:0] seg_sh[NF], blink_sh[NF], seg_app[NF], blink_app[NF];
    int map_m[NF];
    int mid_idx = 0;
    logic [7:0] mid_data = '0;

    always #4 clk = ~clk;

    lcd_mux_driver #(.NUM_FP(NF), .BP_MAX(BP), .PHASE_CYCLES(PC), .FRAME_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mux8_sel(mux8_sel),
        .blink_en(blink_en), .blink_tap(blink_tap), .wr_en(wr_en),
        .wr_target(wr_target), .wr_index(wr_index), .wr_data(wr_data),
        .bp_lvl(bp_lvl), .fp_lvl(fp_lvl));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] ebp(int b, int ph, bit par, int nbp);
        if (b >= nbp) return 2'd0;
        if (b == ph) return par ? 2'd0 : 2'd3;
        return par ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] efp(int pin, int ph, bit par, bit hid);
        int col;
        bit on;
        col = map_m[pin];
        on = 0;
        if (col < NF) on = seg_app[col][ph] && !(hid && blink_app[col][ph]);
        if (on) return par ? 2'd3 : 2'd0;
        return par ? 2'd1 : 2'd2;
    endfunction

    // Config write at a negedge; the model follows the requirements (R9 ignores)
    task automatic cfg_write(input int tgt, input int idx, input logic [7:0] d);
        wr_en = 1'b1; wr_target = 2'(tgt); wr_index = 3'(idx); wr_data = d;
        if (idx < NF) begin
            if (tgt == 0) seg_sh[idx] = d;
            if (tgt == 1) blink_sh[idx] = d;
            if (tgt == 2) map_m[idx] = int'(d[2:0]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_run();
        enable = 1'b1;
        @(negedge clk);
        check("R1 gap", {bp_lvl, fp_lvl}, 32'd0);
        frame_no = 0;
    endtask

    task automatic stop_run();
        enable = 1'b0;
        @(negedge clk);
        check("R1 off", {bp_lvl, fp_lvl}, 32'd0);
    endtask

    // Called at a gap-cycle negedge; checks a whole frame and the next gap.
    // mid: 0 none, 1 staged segment write, 2 mode flip (both during phase 1).
    task automatic check_frame(input int mid, input string tag);
        int nbp;
        bit par, hid;
        logic [2*BP-1:0] xb;
        logic [2*NF-1:0] xf;
        nbp = mux8_sel ? 8 : 4;
        par = frame_no[0];
        hid = blink_en && frame_no[blink_tap];
        for (int c = 0; c < NF; c++) begin
            seg_app[c] = seg_sh[c];
            blink_app[c] = blink_sh[c];
        end
        for (int ph = 0; ph < nbp; ph++) begin
            for (int t = 0; t < PC; t++) begin
                @(negedge clk);
                wr_en = 1'b0;
                for (int b = 0; b < BP; b++) xb[2*b +: 2] = ebp(b, ph, par, nbp);
                for (int p = 0; p < NF; p++) xf[2*p +: 2] = efp(p, ph, par, hid);
                check({tag, " bp"}, 32'(bp_lvl), 32'(xb));
                check({tag, " fp"}, 32'(fp_lvl), 32'(xf));
                if (ph == 1 && t == 0 && mid == 1) begin
                    wr_en = 1'b1; wr_target = 2'd0; wr_index = 3'(mid_idx); wr_data = mid_data;
                    seg_sh[mid_idx] = mid_data;
                end
                if (ph == 1 && t == 0 && mid == 2) mux8_sel = ~mux8_sel;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R3 gap"}, {bp_lvl, fp_lvl}, 32'd0);
        frame_no++;
    endtask

    task automatic t_reset();
        check("R1 reset", {bp_lvl, fp_lvl}, 32'd0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R1 idle", {bp_lvl, fp_lvl}, 32'd0);
    endtask

    task automatic t_basic4();
        for (int c = 0; c < NF; c++) cfg_write(0, c, 8'(8'hA5 ^ (c * 37)));
        mux8_sel = 1'b0;
        start_run();
        check_frame(0, "R2 R3 R4 R5 four");
        check_frame(0, "R2 R4 R5 four odd");
        stop_run();
    endtask

    task automatic t_mode8();
        mux8_sel = 1'b1;
        start_run();
        check_frame(0, "R2 R3 eight");
        check_frame(0, "R4 R5 eight odd");
        stop_run();
    endtask

    task automatic t_mode_latch();
        mux8_sel = 1'b0;
        start_run();
        check_frame(2, "R10 held four");
        check_frame(0, "R10 new eight");
        stop_run();
        mux8_sel = 1'b0;
    endtask

    task automatic t_buffer();
        start_run();
        mid_idx = 2; mid_data = 8'h0F;
        check_frame(1, "R6 old data");
        check_frame(0, "R6 new data");
        mid_idx = 4; mid_data = 8'hF0;
        check_frame(1, "R6 old data 2");
        check_frame(0, "R6 new data 2");
        stop_run();
    endtask

    task automatic t_map();
        cfg_write(2, 0, 8'd5);
        cfg_write(2, 1, 8'd0);
        cfg_write(2, 3, 8'd7);
        cfg_write(2, 5, 8'd6);
        start_run();
        check_frame(0, "R7 remap");
        check_frame(0, "R7 remap odd");
        stop_run();
    endtask

    task automatic t_ignore();
        cfg_write(3, 0, 8'hFF);
        cfg_write(3, 1, 8'h00);
        cfg_write(0, 6, 8'hFF);
        cfg_write(1, 7, 8'hFF);
        cfg_write(2, 6, 8'd1);
        cfg_write(2, 7, 8'd2);
        start_run();
        check_frame(0, "R9 ignored");
        stop_run();
    endtask

    task automatic t_blink();
        for (int c = 0; c < NF; c++) cfg_write(2, c, 8'(c));
        cfg_write(1, 0, 8'hFF);
        cfg_write(1, 1, 8'h0F);
        cfg_write(1, 4, 8'h33);
        blink_en = 1'b1; blink_tap = 2'd0;
        start_run();
        for (int f = 0; f < 4; f++) check_frame(0, "R8 tap0");
        stop_run();
        blink_tap = 2'd1;
        start_run();
        for (int f = 0; f < 4; f++) check_frame(0, "R8 tap1");
        stop_run();
        blink_en = 1'b0;
        start_run();
        check_frame(0, "R8 blink off");
        stop_run();
    endtask

    task automatic t_disable();
        start_run();
        check_frame(0, "R5 first");
        for (int k = 0; k < 4; k++) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R1 mid-frame disable", {bp_lvl, fp_lvl}, 32'd0);
        @(negedge clk);
        check("R1 stays off", {bp_lvl, fp_lvl}, 32'd0);
        start_run();
        check_frame(0, "R5 restart even");
        stop_run();
    endtask

    initial begin
        for (int c = 0; c < NF; c++) begin
            seg_sh[c] = '0; blink_sh[c] = '0; map_m[c] = c;
        end
        #1;
        @(negedge clk);
        t_reset();
        t_basic4();
        t_mode8();
        t_mode_latch();
        t_buffer();
        t_map();
        t_ignore();
        t_blink();
        t_disable();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule